// File: doc/BRIEF.md
# Converter Sample Queue Bank

This block holds converted samples for four conversion sequencers. Each sequencer owns a 16-slot first-in first-out queue. Software sees each queue through a pop port and a packed status word that shows both pointers and the empty and full state. There is no real converter. When sequencer 0 is enabled, each cycle with the trigger input high makes one synthetic sample and pushes it into queue 0. The sample is a fixed base of 0x200 plus three bits taken from a linear congruential generator.

Around the queues sit a small set of registers: sequencer enables, raw and masked interrupt state, and sticky overflow and underflow flags. There are also plain configuration stores for input selection, control, event selection, priority and averaging. The interrupt output is a level signal. Reads return data one cycle after the request. A read of a queue's pop address removes the oldest entry.

Top module: `smpl_fifo_bank`

## Requirements
- R1: After synchronous reset, every queue status word reads 0x100 (empty only, both pointers 0). Every input-select and control store reads 0. All queue slots hold 0. irq is low and bus_rdata is 0.
- R2: The status word at sequencer offset 0x0C has this layout: read pointer in bits [3:0], write pointer in bits [7:4], empty at bit 8, full at bit 12, all other bits 0. A queue holds 16 entries.
- R3: A pop (read of sequencer offset 0x08) of a non-empty queue returns its oldest entry on bus_rdata in the cycle after the request. It advances the read pointer, clears full, and sets empty when the read pointer then equals the write pointer.
- R4: A pop of an empty queue sets bit n of the underflow register (0x18). It leaves that queue's status unchanged and returns the slot at the read pointer.
- R5: A push into a full queue sets bit n of the overflow register (0x10) and discards the sample; the status is unchanged. Otherwise the sample is stored at the write pointer and the write pointer advances. Empty is cleared, and full is set when the write pointer then equals the read pointer.
- R6: In each cycle with trig_in high while enable bit 0 (register 0x00, 4 bits) is set, the generator state s becomes s*314159+1 (mod 2^32; s is 0 after reset). The value 0x200 + s[18:16] of the new state is pushed into queue 0, and raw interrupt bit 0 (0x04) is set. With enable bit 0 clear, the trigger has no effect.
- R7: irq is high exactly when raw (0x04) AND mask (0x08, 4 bits) is non-zero. Reading 0x0C gives raw AND mask. Writing 0x0C clears the raw bits written as one, but a trigger in the same cycle still sets bit 0.
- R8: Overflow (0x10) and underflow (0x18) bits stay set until written with one. A new event in the same cycle as the clear keeps the bit set.
- R9: Input-select writes (sequencer offset 0x00) are masked with 0x33333333. Control (sequencer offset 0x04), event select (0x14), priority (0x20) and averaging (0x30) read back the full 32-bit value written. Sequencer n's registers sit at 0x40 + n*0x20.
- R10: A pop and a push to queue 0 in the same cycle are both honoured, as if the pop came first. On an empty queue the pop underflows and the push is stored. On a full queue the push is accepted, with no overflow, and the queue stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops when addressing a pop port) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| trig_in | input | 1 | Sample trigger, one trigger per high cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle. The first is a trigger-driven push and a software pop of queue 0. The bench raises trig_in and a read of offset 0x48 on the same clock, with queue 0 partly filled, empty and full. It then judges the returned word, the status word and the sticky flags against a queue model that applies the pop first. The second is a trigger and a raw-interrupt clear in the same cycle. It is judged by reading the raw register afterwards and expecting bit 0 to be set.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    // Global register offsets
    localparam int OFF_ENABLE   = 'h00;
    localparam int OFF_RAW      = 'h04;
    localparam int OFF_MASK     = 'h08;
    localparam int OFF_MSTAT    = 'h0C;
    localparam int OFF_OVF      = 'h10;
    localparam int OFF_EVSEL    = 'h14;
    localparam int OFF_UDF      = 'h18;
    localparam int OFF_PRIO     = 'h20;
    localparam int OFF_AVG      = 'h30;

    // Per-sequencer window
    localparam int WIN_BASE     = 'h40;
    localparam int WIN_SHIFT    = 5;
    localparam int WIN_STRIDE   = 1 << WIN_SHIFT;
    localparam int SUB_INSEL    = 'h00;
    localparam int SUB_CTRL     = 'h04;
    localparam int SUB_POP      = 'h08;
    localparam int SUB_STAT     = 'h0C;

    // Status word field positions
    localparam int ST_WP_LSB    = 4;
    localparam int ST_EMPTY_BIT = 8;
    localparam int ST_FULL_BIT  = 12;

    localparam logic [31:0] INSEL_MASK = 32'h3333_3333;

    // Synthetic sample generator
    localparam logic [31:0] LCG_MUL  = 32'd314159;
    localparam int          SMP_BASE = 'h200;
    localparam int          SMP_LSB  = 16;
    localparam int          SMP_NB   = 3;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_POP   = 2'd1,
        Q_PUSH  = 2'd2,
        Q_BOTH  = 2'd3
    } q_op_e;

    function automatic logic [31:0] lcg_next(input logic [31:0] s);
        return s * LCG_MUL + 32'd1;
    endfunction

endpackage

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 12,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] wr_ptr,
    output logic          empty,
    output logic          full,
    output logic          ovf_evt,
    output logic          udf_evt
);
    import sfb_pkg::*;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_n, wr_n;
    logic          pop_ok, push_ok, full_after_pop;
    logic          empty_n, full_n;
    q_op_e         op;

    // Pop is evaluated on the state before the cycle; push sees the state after the pop.
    always_comb begin
        pop_ok         = pop && !empty;
        udf_evt        = pop && empty;
        full_after_pop = full && !pop_ok;
        push_ok        = push && !full_after_pop;
        ovf_evt        = push && full_after_pop;
        op             = q_op_e'({push_ok, pop_ok});
        rd_n           = pop_ok  ? rd_ptr + PW'(1) : rd_ptr;
        wr_n           = push_ok ? wr_ptr + PW'(1) : wr_ptr;
        empty_n        = empty;
        full_n         = full;
        unique case (op)
            Q_POP:  begin empty_n = (rd_n == wr_ptr); full_n = 1'b0; end
            Q_PUSH: begin empty_n = 1'b0; full_n = (wr_n == rd_ptr); end
            Q_BOTH: begin empty_n = 1'b0; full_n = (wr_n == rd_n); end
            default: ;
        endcase
    end

    assign dout = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            empty  <= 1'b1;
            full   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            rd_ptr <= rd_n;
            wr_ptr <= wr_n;
            empty  <= empty_n;
            full   <= full_n;
            if (push_ok) mem[wr_ptr] <= din;
        end
    end

    // R2: empty and full never both set
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R5: overflow leaves pointers and flags alone
    p_ovf_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ($stable(wr_ptr) && $stable(rd_ptr) && full));

    // R4: underflow leaves pointers and flags alone
    p_udf_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> ($stable(wr_ptr) && $stable(rd_ptr) && empty));

    // R10: simultaneous pop and push on a full queue keeps it full
    p_both_full_r10: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full) |=> (full && !empty));

endmodule

// File: rtl/sfb_sample_gen.sv
module sfb_sample_gen #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [SW-1:0] sample
);
    import sfb_pkg::*;

    logic [31:0] state_q;
    logic [31:0] state_n;

    always_comb begin
        state_n = lcg_next(state_q);
        sample  = SW'(SMP_BASE) + SW'(state_n[SMP_LSB +: SMP_NB]);
    end

    always_ff @(posedge clk) begin
        if (rst)       state_q <= '0;
        else if (step) state_q <= state_n;
    end

endmodule

// File: rtl/smpl_fifo_bank.sv
module smpl_fifo_bank
    import sfb_pkg::*;
#(
    parameter int NUM_SEQ = 4,
    parameter int DEPTH   = 16,
    parameter int SMP_W   = 12,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_in,
    output logic              irq
);
    localparam int PW    = $clog2(DEPTH);
    localparam int SEL_W = $clog2(NUM_SEQ);

    // Register state
    logic [NUM_SEQ-1:0] enable_q, raw_q, mask_q, ovf_q, udf_q;
    logic [DATA_W-1:0]  evsel_q, prio_q, avg_q;
    logic [DATA_W-1:0]  insel_q [NUM_SEQ];
    logic [DATA_W-1:0]  ctrl_q  [NUM_SEQ];

    // Decode
    logic [ADDR_W-1:0]    rel;
    logic                 in_win;
    logic [SEL_W-1:0]     sel;
    logic [WIN_SHIFT-1:0] sub;

    assign rel    = bus_addr - ADDR_W'(WIN_BASE);
    assign in_win = (bus_addr >= ADDR_W'(WIN_BASE)) && (rel < ADDR_W'(NUM_SEQ * WIN_STRIDE));
    assign sel    = rel[WIN_SHIFT +: SEL_W];
    assign sub    = rel[WIN_SHIFT-1:0];

    // Queues
    logic [NUM_SEQ-1:0] q_push, q_pop, q_empty, q_full, q_ovf, q_udf;
    logic [SMP_W-1:0]   q_head [NUM_SEQ];
    logic [PW-1:0]      q_rp   [NUM_SEQ];
    logic [PW-1:0]      q_wp   [NUM_SEQ];
    logic [DATA_W-1:0]  q_stat [NUM_SEQ];
    logic [SMP_W-1:0]   sample;
    logic               trig_ok;

    assign trig_ok = trig_in && enable_q[0];

    sfb_sample_gen #(.SW(SMP_W)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .step   (trig_ok),
        .sample (sample)
    );

    for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
        if (n == 0) begin : g_fed
            assign q_push[n] = trig_ok;
        end else begin : g_unfed
            assign q_push[n] = 1'b0;
        end

        assign q_pop[n] = bus_rd && in_win && (sel == SEL_W'(n)) && (sub == WIN_SHIFT'(SUB_POP));

        sfb_fifo #(.DEPTH(DEPTH), .DW(SMP_W)) u_q (
            .clk     (clk),
            .rst     (rst),
            .push    (q_push[n]),
            .pop     (q_pop[n]),
            .din     (sample),
            .dout    (q_head[n]),
            .rd_ptr  (q_rp[n]),
            .wr_ptr  (q_wp[n]),
            .empty   (q_empty[n]),
            .full    (q_full[n]),
            .ovf_evt (q_ovf[n]),
            .udf_evt (q_udf[n])
        );

        always_comb begin
            q_stat[n]                   = '0;
            q_stat[n][PW-1:0]           = q_rp[n];
            q_stat[n][ST_WP_LSB +: PW]  = q_wp[n];
            q_stat[n][ST_EMPTY_BIT]     = q_empty[n];
            q_stat[n][ST_FULL_BIT]      = q_full[n];
        end
    end

    // Set and clear terms for the event registers (set wins)
    logic [NUM_SEQ-1:0] raw_set, raw_clr, ovf_clr, udf_clr;

    always_comb begin
        raw_set    = '0;
        raw_set[0] = trig_ok;
        raw_clr    = (bus_wr && bus_addr == ADDR_W'(OFF_MSTAT)) ? bus_wdata[NUM_SEQ-1:0] : '0;
        ovf_clr    = (bus_wr && bus_addr == ADDR_W'(OFF_OVF))   ? bus_wdata[NUM_SEQ-1:0] : '0;
        udf_clr    = (bus_wr && bus_addr == ADDR_W'(OFF_UDF))   ? bus_wdata[NUM_SEQ-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            raw_q    <= '0;
            mask_q   <= '0;
            ovf_q    <= '0;
            udf_q    <= '0;
            evsel_q  <= '0;
            prio_q   <= '0;
            avg_q    <= '0;
            for (int n = 0; n < NUM_SEQ; n++) begin
                insel_q[n] <= '0;
                ctrl_q[n]  <= '0;
            end
        end else begin
            if (bus_wr && !in_win) begin
                case (bus_addr)
                    ADDR_W'(OFF_ENABLE): enable_q <= bus_wdata[NUM_SEQ-1:0];
                    ADDR_W'(OFF_MASK):   mask_q   <= bus_wdata[NUM_SEQ-1:0];
                    ADDR_W'(OFF_EVSEL):  evsel_q  <= bus_wdata;
                    ADDR_W'(OFF_PRIO):   prio_q   <= bus_wdata;
                    ADDR_W'(OFF_AVG):    avg_q    <= bus_wdata;
                    default: ;
                endcase
            end
            for (int n = 0; n < NUM_SEQ; n++) begin
                if (bus_wr && in_win && sel == SEL_W'(n)) begin
                    if (sub == WIN_SHIFT'(SUB_INSEL)) insel_q[n] <= bus_wdata & INSEL_MASK;
                    if (sub == WIN_SHIFT'(SUB_CTRL))  ctrl_q[n]  <= bus_wdata;
                end
            end
            raw_q <= (raw_q & ~raw_clr) | raw_set;
            ovf_q <= (ovf_q & ~ovf_clr) | q_ovf;
            udf_q <= (udf_q & ~udf_clr) | q_udf;
        end
    end

    // Read path, one cycle latency
    logic [DATA_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        if (in_win) begin
            case (sub)
                WIN_SHIFT'(SUB_INSEL): rd_d = insel_q[sel];
                WIN_SHIFT'(SUB_CTRL):  rd_d = ctrl_q[sel];
                WIN_SHIFT'(SUB_POP):   rd_d = DATA_W'(q_head[sel]);
                WIN_SHIFT'(SUB_STAT):  rd_d = q_stat[sel];
                default: ;
            endcase
        end else begin
            case (bus_addr)
                ADDR_W'(OFF_ENABLE): rd_d = DATA_W'(enable_q);
                ADDR_W'(OFF_RAW):    rd_d = DATA_W'(raw_q);
                ADDR_W'(OFF_MASK):   rd_d = DATA_W'(mask_q);
                ADDR_W'(OFF_MSTAT):  rd_d = DATA_W'(raw_q & mask_q);
                ADDR_W'(OFF_OVF):    rd_d = DATA_W'(ovf_q);
                ADDR_W'(OFF_EVSEL):  rd_d = evsel_q;
                ADDR_W'(OFF_UDF):    rd_d = DATA_W'(udf_q);
                ADDR_W'(OFF_PRIO):   rd_d = prio_q;
                ADDR_W'(OFF_AVG):    rd_d = avg_q;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_d;
    end

    assign irq = |(raw_q & mask_q);

    // R6: an accepted trigger leaves raw bit 0 set
    p_trig_raw_r6: assert property (@(posedge clk) disable iff (rst)
        trig_ok |=> raw_q[0]);

    // R6: a trigger with sequencer 0 disabled does not move queue 0's write pointer
    p_trig_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (trig_in && !enable_q[0]) |=> $stable(q_wp[0]));

    // R8: overflow bit 0 stays set unless the clear register is written
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_q[0] && !(bus_wr && bus_addr == ADDR_W'(OFF_OVF))) |=> ovf_q[0]);

    // R8: underflow bits only rise on a pop
    p_udf_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> !$rose(udf_q[0]));

endmodule

// File: tb/sim_smpl_fifo_bank.sv
`timescale 1ns/1ps
module sim_smpl_fifo_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_in = 1'b0;
    logic        irq;

    always #10 clk = ~clk;

    smpl_fifo_bank u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // Queue model for queue 0
    logic [11:0] mm [16];
    int          mh = 0, mt = 0;
    bit          me = 1, mf = 0;
    logic [31:0] ms = 0;
    logic [3:0]  m_ovf = 0, m_udf = 0, m_raw = 0, m_en = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] m_stat();
        logic [31:0] s = '0;
        s[3:0] = mt[3:0];
        s[7:4] = mh[3:0];
        s[8]   = me;
        s[12]  = mf;
        return s;
    endfunction

    task automatic m_pop(output logic [31:0] v);
        v = {20'd0, mm[mt]};
        if (me) m_udf[0] = 1'b1;
        else begin
            mt = (mt + 1) % 16;
            mf = 0;
            if (mt == mh) me = 1;
        end
    endtask

    task automatic m_trig();
        if (m_en[0]) begin
            logic [11:0] v;
            ms = ms * 32'd314159 + 32'd1;
            v  = 12'h200 + {9'd0, ms[18:16]};
            m_raw[0] = 1'b1;
            if (mf) m_ovf[0] = 1'b1;
            else begin
                mm[mh] = v;
                mh = (mh + 1) % 16;
                me = 0;
                if (mh == mt) mf = 1;
            end
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        m_trig();
    endtask

    // Pop queue 0 and trigger in the same cycle; model applies pop first (R10)
    task automatic pulse_pop(input string req);
        logic [31:0] exp, d;
        @(negedge clk);
        trig_in = 1'b1; bus_addr = 8'h48; bus_rd = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; bus_rd = 1'b0;
        d = bus_rdata;
        m_pop(exp);
        m_trig();
        chk(req, d, exp);
    endtask

    task automatic pop_chk(input string req);
        logic [31:0] exp, d;
        rd(8'h48, d);
        m_pop(exp);
        chk(req, d, exp);
    endtask

    task automatic stat_chk(input string req);
        logic [31:0] d;
        rd(8'h4C, d);
        chk(req, d, m_stat());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 16; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        for (int n = 0; n < 4; n++) begin
            logic [7:0] b = 8'(8'h40 + n * 8'h20);
            rd(b + 8'h0C, d); chk("R1 status", d, 32'h100);
            rd(b + 8'h00, d); chk("R1 insel", d, 0);
            rd(b + 8'h04, d); chk("R1 ctrl", d, 0);
        end

        // R9: register stores
        for (int n = 0; n < 4; n++) begin
            logic [7:0] b = 8'(8'h40 + n * 8'h20);
            wr(b, 32'hFFFF_FFFF);
            rd(b, d); chk("R9 insel mask", d, 32'h3333_3333);
            wr(b + 8'h04, 32'hDEAD_0000 | n);
            rd(b + 8'h04, d); chk("R9 ctrl", d, 32'hDEAD_0000 | n);
        end
        wr(8'h14, 32'hA5A5_0F0F); rd(8'h14, d); chk("R9 evsel", d, 32'hA5A5_0F0F);
        wr(8'h20, 32'h0000_3210); rd(8'h20, d); chk("R9 prio", d, 32'h0000_3210);
        wr(8'h30, 32'h0000_0006); rd(8'h30, d); chk("R9 avg", d, 32'h0000_0006);
        wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, d); chk("R9 enable width", d, 32'hE);

        // R6: trigger ignored with sequencer 0 disabled
        m_en = 4'hE;
        pulse();
        stat_chk("R6 disabled trigger status");
        rd(8'h04, d); chk("R6 disabled trigger raw", d, 0);

        // R6/R2/R5: fill sweep with two overflowing pushes
        wr(8'h00, 32'h1); m_en = 4'h1;
        for (int k = 0; k < 18; k++) begin
            pulse();
            stat_chk("R2 R5 fill status");
        end
        rd(8'h10, d); chk("R5 overflow flag", d, {28'd0, m_ovf});
        rd(8'h04, d); chk("R6 raw set", d, {28'd0, m_raw});

        // R7: interrupt masking and clearing
        chk("R7 irq masked", {31'd0, irq}, 0);
        wr(8'h08, 32'hF); @(negedge clk);
        chk("R7 irq unmasked", {31'd0, irq}, 1);
        rd(8'h0C, d); chk("R7 masked status", d, 32'h1);
        wr(8'h0C, 32'h1); m_raw[0] = 0; @(negedge clk);
        chk("R7 irq cleared", {31'd0, irq}, 0);

        // R3: drain with oldest-first order
        for (int k = 0; k < 16; k++) begin
            pop_chk("R3 pop data");
            stat_chk("R3 pop status");
        end

        // R4: underflow on queue 0 and queue 2
        pop_chk("R4 underflow data");
        stat_chk("R4 underflow status");
        rd(8'h88, d); chk("R4 underflow data q2", d, 0); m_udf[2] = 1;
        rd(8'h8C, d); chk("R4 underflow status q2", d, 32'h100);
        rd(8'h18, d); chk("R4 underflow flags", d, {28'd0, m_udf});

        // R8: write-one-to-clear
        wr(8'h18, 32'h1); m_udf[0] = 0;
        rd(8'h18, d); chk("R8 udf partial clear", d, {28'd0, m_udf});
        wr(8'h10, 32'h1); m_ovf[0] = 0;
        rd(8'h10, d); chk("R8 ovf clear", d, 0);

        // R10: same-cycle pop and push, partly filled
        pulse(); pulse(); pulse();
        pulse_pop("R10 both partial data");
        stat_chk("R10 both partial status");
        for (int k = 0; k < 3; k++) pop_chk("R10 drain");
        // R10: on empty queue
        pulse_pop("R10 both empty data");
        stat_chk("R10 both empty status");
        rd(8'h18, d); chk("R10 both empty udf", d, {28'd0, m_udf});
        // R10: on full queue
        while (!mf) pulse();
        pulse_pop("R10 both full data");
        stat_chk("R10 both full status");
        rd(8'h10, d); chk("R10 both full no ovf", d, {28'd0, m_ovf});

        // R7: trigger wins over a same-cycle raw clear
        for (int k = 0; k < 16; k++) pop_chk("R7 drain");
        @(negedge clk);
        trig_in = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; bus_wr = 1'b0;
        m_raw[0] = 0; m_trig();
        rd(8'h04, d); chk("R7 set wins", d, {28'd0, m_raw});
        stat_chk("R6 push during clear");

        // R8: overflow set in same cycle as clear stays set
        while (!mf) pulse();
        @(negedge clk);
        trig_in = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; bus_wr = 1'b0;
        m_ovf[0] = 0; m_trig();
        rd(8'h10, d); chk("R8 set wins", d, {28'd0, m_ovf});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule